// File: doc/BRIEF.md
# Gated Multi-Source Frequency Meter

This block measures how fast one of up to 32 candidate clocks is running. A gate timer in the reference clock domain opens a window that lasts a programmed number of microseconds. During that window an edge counter, clocked by the selected source, counts rising edges. When the window closes, the count is returned to the reference domain and placed in a result register, and the busy indication drops. Software starts a measurement through a control word, polls the busy bit, and then reads the count. For a 64 µs window, the source frequency in MHz is the count plus 31, shifted right by six.

The microsecond tick comes from the reference clock through a prescaler of `TICK_DIV` cycles. The prescaler restarts at the beginning of every window. The gate level is passed into the measured domain through a two-flop synchronizer. Completion comes back as a toggle through another two-flop synchronizer, so the count is already frozen when it is captured. The meter can run once per start or repeat windows back to back. It can raise a one-cycle interrupt pulse at each capture.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word (address 0) and the result register (address 1) both read 0, and `irq` is low.
- R2: The control word holds writable fields: gate length minus one in bits [15:0], run in bit 16, repeat in bit 17, interrupt enable in bit 18, source clock enable in bit 19, and source index in bits [24:20]. These fields read back as written. Bits [30:25] always read 0. Bit 31 reads the busy state.
- R3: Writing run=1 when the stored run bit is 0 and the meter is idle starts a window, and bit 31 reads 1 from the next cycle. The window lasts (gate+1)·`TICK_DIV` reference cycles. When the source is not counted, busy reads 1 for exactly that many cycles.
- R4: Address 1 returns the number of rising edges of the selected source inside the window in bits [19:0], within ±2 of window/period. Bits [31:20] read 0.
- R5: The source index picks `src_clk[index]`, so different sources give their own counts.
- R6: If bit 19 is clear, or the index is not below `NSRC`, the result is 0 and busy still clears when the window ends.
- R7: The edge count saturates at 2^`CNT_W`−1 instead of wrapping.
- R8: In one-shot mode (bit 17 clear), the meter stays idle after a capture while run stays 1, and the result is kept. Writing run=1 again without clearing it first does not restart the meter.
- R9: With bit 17 set, windows repeat, busy stays 1 and the result is refreshed. Clearing run ends the sequence after the current window.
- R10: With bit 18 set, `irq` pulses high for one cycle at each capture. With bit 18 clear, `irq` stays low.
- R11: The result changes only at a capture. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the register clock |
| rst | input | 1 | Synchronous active-high reset (asynchronous in the measured domain) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_clk | input | NSRC | Candidate clocks to measure |
| irq | output | 1 | One-cycle pulse on capture when enabled |

## Verification
Busy rises one cycle after the start write. When the source is not counted, busy falls exactly (gate+1)·`TICK_DIV` cycles after that write, and the bench counts those cycles at falling edges. When the source is counted, the finish is delayed by a variable number of synchronizer cycles. So the bench polls bit 31 at each falling edge, and it pops the expected count range from its queue only once busy reads 0, because the result is loaded in the same cycle that busy drops. Counts are compared as ranges of ±2 edges to absorb synchronizer alignment, with one exception: the saturated count must match exactly. Interrupt pulses are counted on every falling edge, and the bench flags any pulse longer than one cycle.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
    localparam int GATE_W = 16;
    localparam int SEL_W  = 5;
    localparam int RES_W  = 20;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_RES  = 1'b1;

    // Control word; field positions are software visible
    typedef struct packed {
        logic              busy;      // 31
        logic [5:0]        spare;     // 30:25
        logic [SEL_W-1:0]  src;       // 24:20
        logic              clk_on;    // 19
        logic              irq_on;    // 18
        logic              repeat_on; // 17
        logic              run;       // 16
        logic [GATE_W-1:0] gate_m1;   // 15:0
    } ctrl_t;

    // Configuration frozen at the start of a measurement
    typedef struct packed {
        logic [GATE_W-1:0] gate_m1;
        logic [SEL_W-1:0]  src;
        logic              clk_on;
        logic              live;
    } run_cfg_t;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_GATE  = 2'd1,
        MS_DRAIN = 2'd2
    } mstate_e;

    function automatic ctrl_t to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        c.busy  = 1'b0;
        c.spare = '0;
        return c;
    endfunction

    function automatic logic src_counted(input ctrl_t c, input int nsrc);
        return c.clk_on && (int'(c.src) < nsrc);
    endfunction
endpackage

// File: rtl/fm_sync2.sv
`timescale 1ns/1ps
module fm_sync2 #(
    parameter bit ASYNC_RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [1:0] ff;

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or posedge rst) begin
                if (rst) ff <= '0;
                else     ff <= {ff[0], d};
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[0], d};
            end
        end
    endgenerate

    assign q = ff[1];
endmodule

// File: rtl/fm_src_mux.sv
`timescale 1ns/1ps
module fm_src_mux #(
    parameter int NSRC  = 32,
    parameter int SEL_W = 5
) (
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             mclk
);
    logic [NSRC-1:0] hit;

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_leg
            assign hit[k] = src_clk[k] & (sel == SEL_W'(k));
        end
    endgenerate

    assign mclk = en & (|hit);
endmodule

// File: rtl/fm_gate_timer.sv
`timescale 1ns/1ps
module fm_gate_timer #(
    parameter int DIV    = 24,
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic [GATE_W-1:0] gate_m1,
    output logic              win_end
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [GATE_W-1:0] us_q;
    logic              tick;

    assign tick    = run && (pre_q == PRE_LAST);
    assign win_end = tick && (us_q == gate_m1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) us_q <= (us_q == gate_m1) ? '0 : us_q + 1'b1;
        end
    end

    // R3
    us_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (us_q <= gate_m1));
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
    parameter int CNT_W = 20
) (
    input  logic             mclk,
    input  logic             rst,
    input  logic             gate_ref,
    output logic [CNT_W-1:0] cnt,
    output logic             done_tgl
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             gate_s;
    logic             gate_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q;

    fm_sync2 #(.ASYNC_RST(1'b1)) i_gate_sync (
        .clk (mclk),
        .rst (rst),
        .d   (gate_ref),
        .q   (gate_s)
    );

    always_ff @(posedge mclk or posedge rst) begin
        if (rst) begin
            gate_d <= 1'b0;
            cnt_q  <= '0;
            tgl_q  <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d)             cnt_q <= CNT_W'(1);
            else if (gate_s && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (!gate_s && gate_d) tgl_q <= ~tgl_q;
        end
    end

    assign cnt      = cnt_q;
    assign done_tgl = tgl_q;

    // R7
    cnt_sat_chk: assert property (@(posedge mclk) disable iff (rst)
        (gate_s && gate_d && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    // R11
    cnt_frozen_chk: assert property (@(posedge mclk) disable iff (rst)
        (!gate_s) |=> $stable(cnt_q));
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
    import fm_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int TICK_DIV = 24,
    parameter int CNT_W    = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NSRC-1:0] src_clk,
    output logic            irq
);
    ctrl_t            ctrl_q;
    ctrl_t            wr_c;
    ctrl_t            rd_c;
    run_cfg_t         cfg_q;
    mstate_e          state_q;
    logic [RES_W-1:0] result_q;
    logic             irq_q;

    logic             busy;
    logic             start;
    logic             again;
    logic             restart;
    logic             capture;
    logic             win_end;
    logic             gate_on;
    logic             mclk;
    logic [CNT_W-1:0] cnt;
    logic             done_tgl;
    logic             ack_s;
    logic             ack_d;
    logic             ack_edge;

    assign wr_c     = to_ctrl(reg_wdata);
    assign busy     = (state_q != MS_IDLE);
    assign gate_on  = (state_q == MS_GATE);
    assign start    = reg_wr && (reg_addr == ADDR_CTRL) && wr_c.run
                      && !ctrl_q.run && (state_q == MS_IDLE);
    assign again    = ctrl_q.repeat_on && ctrl_q.run;
    assign ack_edge = ack_s ^ ack_d;
    assign capture  = (gate_on && win_end && !cfg_q.live)
                   || ((state_q == MS_DRAIN) && ack_edge);
    assign restart  = start || (capture && again);

    fm_gate_timer #(.DIV(TICK_DIV), .GATE_W(GATE_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (gate_on),
        .gate_m1 (cfg_q.gate_m1),
        .win_end (win_end)
    );

    fm_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) i_mux (
        .src_clk (src_clk),
        .sel     (cfg_q.src),
        .en      (cfg_q.clk_on),
        .mclk    (mclk)
    );

    fm_edge_counter #(.CNT_W(CNT_W)) i_counter (
        .mclk     (mclk),
        .rst      (rst),
        .gate_ref (gate_on),
        .cnt      (cnt),
        .done_tgl (done_tgl)
    );

    fm_sync2 #(.ASYNC_RST(1'b0)) i_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (done_tgl),
        .q   (ack_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cfg_q    <= '0;
            state_q  <= MS_IDLE;
            result_q <= '0;
            irq_q    <= 1'b0;
            ack_d    <= 1'b0;
        end else begin
            ack_d <= ack_s;
            irq_q <= capture && ctrl_q.irq_on;
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= wr_c;
            if (start) begin
                cfg_q.gate_m1 <= wr_c.gate_m1;
                cfg_q.src     <= wr_c.src;
                cfg_q.clk_on  <= wr_c.clk_on;
                cfg_q.live    <= src_counted(wr_c, NSRC);
            end
            if (capture) result_q <= cfg_q.live ? RES_W'(cnt) : '0;
            case (state_q)
                MS_IDLE:  if (start) state_q <= MS_GATE;
                MS_GATE:  if (win_end) begin
                              if (cfg_q.live) state_q <= MS_DRAIN;
                              else            state_q <= again ? MS_GATE : MS_IDLE;
                          end
                MS_DRAIN: if (ack_edge) state_q <= again ? MS_GATE : MS_IDLE;
                default:  state_q <= MS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_c       = ctrl_q;
        rd_c.busy  = busy;
        rd_c.spare = '0;
        reg_rdata  = (reg_addr == ADDR_CTRL) ? 32'(rd_c) : 32'(result_q);
    end

    assign irq = irq_q;

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(capture));

    // R6
    dead_src_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && !cfg_q.live) |=> (result_q == '0));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(capture) && $past(ctrl_q.irq_on)));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!capture) |=> $stable(result_q));
endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
    localparam int CLK_P = 10;
    localparam int NSRC  = 22;
    localparam int DIV   = 4;
    localparam int CNTW  = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic            reg_addr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] src = '0;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    int irq_wide = 0;
    logic irq_prev = 1'b0;

    typedef struct {
        string tag;
        int    lo;
        int    hi;
    } exp_t;
    exp_t sb_q[$];

    freq_meter #(.NSRC(NSRC), .TICK_DIV(DIV), .CNT_W(CNTW)) i_freq_meter (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_clk   (src),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;
    initial forever #2  src[0] = ~src[0];   // 4 ns
    initial forever #3  src[1] = ~src[1];   // 6 ns
    initial forever #8  src[2] = ~src[2];   // 16 ns
    initial forever #25 src[3] = ~src[3];   // 50 ns

    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (irq && irq_prev) irq_wide++;
            irq_prev = irq;
        end
    end

    function automatic logic [31:0] cfg(int g, bit run, bit rep, bit ie, bit ce, int s);
        return (32'(s) << 20) | (32'(ce) << 19) | (32'(ie) << 18)
             | (32'(rep) << 17) | (32'(run) << 16) | 32'(g & 16'hFFFF);
    endfunction

    task automatic chk_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(string req, longint act, longint lo, longint hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr_reg(logic a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd_reg(logic a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        for (int i = 0; i < 50000; i++) begin
            rd_reg(1'b0, v);
            if (!v[31]) return;
            cyc++;
            @(negedge clk);
        end
        chk_eq("R3 busy never cleared", 1, 0);
    endtask

    task automatic launch(logic [31:0] c);
        wr_reg(1'b0, c & ~32'h0001_0000);
        wr_reg(1'b0, c | 32'h0001_0000);
    endtask

    task automatic expect_cnt(string tag, int lo, int hi);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi;
        sb_q.push_back(e);
    endtask

    task automatic pop_check();
        exp_t e;
        logic [31:0] v;
        e = sb_q.pop_front();
        rd_reg(1'b1, v);
        chk_rng(e.tag, v[19:0], e.lo, e.hi);
        chk_eq("R4 result upper bits", v[31:20], 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep;
        int cyc;
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, v); chk_eq("R1 ctrl after reset", v, 0);
        rd_reg(1'b1, v); chk_eq("R1 result after reset", v, 0);
        chk_eq("R1 irq after reset", irq, 0);

        // R2 field readback, spare bits read zero, no start without run
        wr_reg(1'b0, cfg(16'h1234, 0, 1, 1, 1, 21) | 32'h7E00_0000);
        rd_reg(1'b0, v);
        chk_eq("R2 ctrl readback", v, cfg(16'h1234, 0, 1, 1, 1, 21));
        wr_reg(1'b0, 32'h0);

        // R3 R4 one-shot on source 0: 2000 ns / 4 ns
        expect_cnt("R4 src0 count", 498, 502);
        launch(cfg(49, 1, 0, 0, 1, 0));
        rd_reg(1'b0, v); chk_eq("R3 busy after start", v[31], 1);
        wait_idle(cyc);
        pop_check();

        // R8 stays idle with run held, rewriting run does not restart
        rd_reg(1'b1, keep);
        repeat (100) @(negedge clk);
        rd_reg(1'b0, v); chk_eq("R8 idle while run held", v[31], 0);
        wr_reg(1'b0, cfg(49, 1, 0, 0, 1, 0));
        rd_reg(1'b0, v); chk_eq("R8 rewrite run no restart", v[31], 0);
        rd_reg(1'b1, v); chk_eq("R8 result kept", v, keep);

        // R11 result write ignored
        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd_reg(1'b1, v); chk_eq("R11 result write ignored", v, keep);

        // R5 other sources: 1200 ns windows
        expect_cnt("R5 src1 count", 198, 202);
        launch(cfg(29, 1, 0, 0, 1, 1)); wait_idle(cyc); pop_check();
        expect_cnt("R5 src2 count", 73, 77);
        launch(cfg(29, 1, 0, 0, 1, 2)); wait_idle(cyc); pop_check();
        expect_cnt("R5 src3 count", 22, 26);
        launch(cfg(29, 1, 0, 0, 1, 3)); wait_idle(cyc); pop_check();

        // R6 R3 clock disabled: zero count, exact window length
        expect_cnt("R6 disabled clock count", 0, 0);
        launch(cfg(4, 1, 0, 0, 0, 0)); wait_idle(cyc);
        chk_eq("R3 window cycles disabled clock", cyc, 5 * DIV);
        pop_check();

        // R6 index beyond populated sources
        expect_cnt("R6 out of range count", 0, 0);
        launch(cfg(4, 1, 0, 0, 1, 25)); wait_idle(cyc);
        chk_eq("R6 window cycles out of range", cyc, 5 * DIV);
        pop_check();

        // R7 saturation: 20000 ns / 4 ns exceeds 4095
        expect_cnt("R7 saturated count", 4095, 4095);
        launch(cfg(499, 1, 0, 0, 1, 0)); wait_idle(cyc); pop_check();

        // R10 no interrupt when disabled
        base = irq_cnt;
        expect_cnt("R10 count without irq", 73, 77);
        launch(cfg(29, 1, 0, 0, 1, 2)); wait_idle(cyc); pop_check();
        repeat (3) @(negedge clk);
        chk_eq("R10 no irq when disabled", irq_cnt - base, 0);

        // R9 R10 continuous with interrupts: 400 ns / 16 ns
        base = irq_cnt;
        launch(cfg(9, 1, 1, 1, 1, 2));
        for (int i = 0; i < 20000 && (irq_cnt - base) < 3; i++) @(negedge clk);
        chk_rng("R10 irq pulses seen", irq_cnt - base, 3, 3);
        rd_reg(1'b0, v); chk_eq("R9 busy held in repeat", v[31], 1);
        expect_cnt("R9 repeat count", 23, 27);
        pop_check();
        wr_reg(1'b0, cfg(9, 0, 1, 1, 1, 2));
        wait_idle(cyc);
        base = irq_cnt;
        repeat (200) @(negedge clk);
        rd_reg(1'b0, v); chk_eq("R9 stopped after run cleared", v[31], 0);
        chk_eq("R9 no further captures", irq_cnt - base, 0);
        chk_eq("R10 irq single cycle", irq_wide, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule